// File: doc/BRIEF.md
# Register-Driven Two-Wire Codec Write Master

This block lets a host write one codec register over an I2C bus with two register writes. The host first stores a 32-bit word in the data register. The upper half of that word holds the frame: a 7-bit register number in bits 31:25 and 9-bit register data in bits 24:16. The host then writes the control register with the device address byte in bits 7:0, and with bits 8 and 10 both set. This starts the transfer.

The block sends a START, the address byte, the high frame byte and the low frame byte. After each byte it samples the target's acknowledge, and it ends with a STOP. Bits go out MSB first. At the end of the transfer the block clears control bit 8 by itself. If the target fails to acknowledge any byte, the block goes straight to STOP and sets control bit 9 to mark the abort. The SCL and SDA pads are open drain: each output below is an enable that pulls its line low.

SCL runs at one quarter-phase per `CLK_DIV` system clocks, so one SCL period is `4*CLK_DIV` clocks. While a transfer is running, the register contents stay frozen.

Top module: `i2cw_master`

## Requirements
- R1: After reset, `ctrl_q` and `data_q` read 0, and both `scl_oe` and `sda_oe` are 0 (lines released). Both pad enables stay 0 whenever no transfer is running.
- R2: When control bit 8 is 0, a write with `reg_sel`=0 stores all 32 bits of `reg_wdata` into `data_q`. The frame is `data_q[31:16]`: register number in bits 31:25 and data in bits 24:16.
- R3: When control bit 8 is 0, a write with `reg_sel`=1 stores the address byte from bits 7:0 and bit 10. It starts a transfer, with bit 8 reading 1, only if bits 8 and 10 are both 1. With bit 8 set and bit 10 clear, bit 8 stays 0 and the bus stays idle.
- R4: A transfer on the bus is, in order: START, the address byte, ACK slot, `data_q[31:24]`, ACK slot, `data_q[23:16]`, ACK slot, STOP. Each byte goes MSB first, and SDA is released in the ACK slots.
- R5: Each SCL high pulse inside a byte lasts `2*CLK_DIV` clocks. SDA changes while SCL is high only to form START (falling) or STOP (rising).
- R6: With every slot acknowledged, bit 8 reads 0 exactly `113*CLK_DIV` clock edges after the edge that started the transfer, and bit 9 reads 0.
- R7: When ACK slot j (j = 1, 2 or 3) sees SDA high, the block skips the remaining bytes and sends STOP. Bit 9 is set, and bit 8 clears `(5+36*j)*CLK_DIV` edges after the start edge.
- R8: While bit 8 reads 1, writes to either register are ignored. This includes a write that lands on the same edge that clears bit 8.
- R9: Starting a new transfer clears bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the data register, 1 selects the control register |
| reg_wdata | input | 32 | Write data |
| ctrl_q | output | 32 | Control register: [7:0] address byte, [8] busy/valid, [9] abort, [10] write select |
| data_q | output | 32 | Data register contents |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
Two events can fall on the same clock edge: the hardware clearing bit 8 at the end of a transfer, and a host write to the data register. The bench works out the finishing edge from R6. It drives a data write so that the write hits exactly that edge, then checks that `data_q` kept its old value and that a write one cycle later is accepted. A second overlap is provoked by a NACK, which sets bit 9, followed by a new start that must clear bit 9. Both are judged at the ports against cycle counts the bench computes itself.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int FRAME_BYTES = 3;
  localparam int SLOT_BITS   = 9;
  localparam int FRAME_SLOTS = FRAME_BYTES * SLOT_BITS;
  localparam int PAY_W       = FRAME_BYTES * 8;
  localparam int IDX_W       = $clog2(FRAME_SLOTS);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_SHIFT,
    ST_STOP
  } eng_state_t;

  // True when slot index lands on the acknowledge position of a byte
  function automatic logic slot_is_ack(input logic [IDX_W-1:0] idx);
    return (int'(idx) % SLOT_BITS) == 8;
  endfunction

  // Data level for a slot; ack slots release the line (1)
  function automatic logic slot_bit(input logic [PAY_W-1:0] p,
                                    input logic [IDX_W-1:0] idx);
    int b;
    int k;
    b = int'(idx) / SLOT_BITS;
    k = int'(idx) % SLOT_BITS;
    if (k > 7) return 1'b1;
    return p[PAY_W - 1 - b * 8 - k];
  endfunction
endpackage

// File: rtl/i2cw_clkdiv.sv
module i2cw_clkdiv #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic busy,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (go || !busy)    cnt <= '0;
    else if (tick)           cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cw_regs.sv
module i2cw_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic        nack_evt,
  input  logic        done_evt,
  output logic        go,
  output logic [31:0] ctrl_q,
  output logic [31:0] data_q
);
  logic [7:0] addr_q;
  logic       wsel_q;
  logic       valid_q;
  logic       abort_q;
  logic       unused_ctrl_bits;

  assign unused_ctrl_bits = ^{reg_wdata[31:11], reg_wdata[9]};
  assign go = reg_wr && reg_sel && !valid_q && reg_wdata[8] && reg_wdata[10];
  assign ctrl_q = {21'd0, wsel_q, abort_q, valid_q, addr_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      addr_q  <= '0;
      wsel_q  <= 1'b0;
      valid_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (reg_wr && !valid_q) begin
        if (!reg_sel) begin
          data_q <= reg_wdata;
        end else begin
          addr_q <= reg_wdata[7:0];
          wsel_q <= reg_wdata[10];
        end
      end
      if (go) begin
        valid_q <= 1'b1;
        abort_q <= 1'b0;
      end
      if (nack_evt) abort_q <= 1'b1;
      if (done_evt) valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
  import i2cw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             tick,
  input  logic [PAY_W-1:0] payload,
  input  logic             sda_in,
  output logic             busy,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             nack_evt,
  output logic             done_evt,
  output logic             in_start,
  output logic             in_stop
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_SLOTS - 1);

  eng_state_t       state;
  logic [1:0]       ph;
  logic [IDX_W-1:0] idx;
  logic             cur_ack;
  logic             cur_bit;

  assign cur_ack  = slot_is_ack(idx);
  assign cur_bit  = slot_bit(payload, idx);
  assign busy     = (state != ST_IDLE);
  assign in_start = (state == ST_START);
  assign in_stop  = (state == ST_STOP);
  assign nack_evt = tick && (state == ST_SHIFT) && (ph == 2'd3) && cur_ack && sda_in;
  assign done_evt = tick && (state == ST_STOP) && (ph == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ph    <= '0;
      idx   <= '0;
    end else if (go) begin
      state <= ST_START;
      ph    <= '0;
      idx   <= '0;
    end else if (tick) begin
      case (state)
        ST_START: begin
          if (ph == 2'd1) begin
            state <= ST_SHIFT;
            ph    <= '0;
          end else ph <= ph + 2'd1;
        end
        ST_SHIFT: begin
          if (ph == 2'd3) begin
            ph <= '0;
            if (nack_evt || idx == LAST_IDX) state <= ST_STOP;
            else idx <= idx + 1'b1;
          end else ph <= ph + 2'd1;
        end
        ST_STOP: begin
          if (ph == 2'd2) begin
            state <= ST_IDLE;
            ph    <= '0;
          end else ph <= ph + 2'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (state)
      ST_START: begin
        sda_oe = 1'b1;
        scl_oe = (ph == 2'd1);
      end
      ST_SHIFT: begin
        scl_oe = (ph < 2'd2);
        sda_oe = !cur_ack && !cur_bit;
      end
      ST_STOP: begin
        scl_oe = (ph == 2'd0);
        sda_oe = (ph != 2'd2);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/i2cw_master.sv
module i2cw_master
  import i2cw_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] ctrl_q,
  output logic [31:0] data_q,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  logic             go;
  logic             tick;
  logic             busy;
  logic             nack_evt;
  logic             done_evt;
  logic             in_start;
  logic             in_stop;
  logic             valid_w;
  logic             abort_w;
  logic [PAY_W-1:0] payload;

  assign valid_w = ctrl_q[8];
  assign abort_w = ctrl_q[9];
  assign payload = {ctrl_q[7:0], data_q[31:16]};

  i2cw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .nack_evt(nack_evt), .done_evt(done_evt),
    .go(go), .ctrl_q(ctrl_q), .data_q(data_q)
  );

  i2cw_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .tick(tick)
  );

  i2cw_engine u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .tick(tick), .payload(payload),
    .sda_in(sda_in), .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .nack_evt(nack_evt), .done_evt(done_evt), .in_start(in_start),
    .in_stop(in_stop)
  );
endmodule

// File: rtl/i2cw_master_chk.sv
module i2cw_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [31:0] data_q,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        busy,
  input logic        go,
  input logic        valid_w,
  input logic        abort_w,
  input logic        nack_evt,
  input logic        done_evt,
  input logic        in_start,
  input logic        in_stop
);
  AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe)); // R1

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> (in_start || in_stop)); // R5

  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && valid_w) |=> $stable(data_q)); // R8

  AST_NACK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> abort_w); // R7

  AST_DONE_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !valid_w); // R6

  AST_START_CLEARS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (valid_w && !abort_w)); // R9
endmodule

bind i2cw_master i2cw_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .data_q(data_q), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
  .go(go), .valid_w(valid_w), .abort_w(abort_w), .nack_evt(nack_evt),
  .done_evt(done_evt), .in_start(in_start), .in_stop(in_stop)
);

// File: tb/tb_i2cw_master.sv
`timescale 1ns/1ps
module tb_i2cw_master;
  localparam int D = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] ctrl_q;
  logic [31:0] data_q;
  logic        scl_oe;
  logic        sda_oe;
  logic        sda_in;
  logic        pull = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int nstart = 0;
  int nstop = 0;
  int mbits = 0;
  int bad_hi = 0;
  int cyc = 0;
  int rise_t = 0;
  bit rise_seen = 0;
  bit prev_scl = 1;
  bit prev_sda = 1;
  bit finished = 0;
  logic [7:0] rx [3];
  logic [2:0] ack_en = 3'b111;

  always #2.5 clk = ~clk;

  assign sda_in = !(sda_oe || pull);

  i2cw_master #(.CLK_DIV(D)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_q(ctrl_q), .data_q(data_q),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_cycles(input int k);
    if (k >= 3) return 113 * D;
    return (5 + 36 * (k + 1)) * D;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [31:0] dv, input logic [7:0] ad, input int i);
    if (i == 0) return ad;
    if (i == 1) return dv[31:24];
    return dv[23:16];
  endfunction

  // Target model watching the bus lines
  always @(negedge clk) begin
    bit scl_l;
    bit sda_l;
    int pos;
    cyc++;
    scl_l = !scl_oe;
    sda_l = !(sda_oe || pull);
    if (rst_n) begin
      if (scl_l && prev_scl && prev_sda && !sda_l) begin
        nstart++; mbits = 0; rise_seen = 0; pull = 0;
      end else if (scl_l && prev_scl && !prev_sda && sda_l) begin
        nstop++;
      end
      if (scl_l && !prev_scl) begin
        pos = mbits % 9;
        if (pos < 8 && mbits < 27) rx[mbits / 9][7 - pos] = sda_l;
        mbits++;
        rise_seen = 1;
        rise_t = cyc;
      end
      if (!scl_l && prev_scl) begin
        if (rise_seen && (cyc - rise_t) != 2 * D) bad_hi++;
        rise_seen = 0;
        if (mbits % 9 == 8 && mbits / 9 < 3) pull = ack_en[mbits / 9];
        else pull = 0;
      end
    end
    prev_scl = scl_l;
    prev_sda = !(sda_oe || pull);
  end

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic txn(input logic [6:0] regn, input logic [8:0] d9, input logic [7:0] ad,
                     input logic [2:0] mask, input bit collide);
    logic [31:0] dv;
    int k;
    int kk;
    int ecyc;
    int cnt;
    int s0;
    int p0;
    dv = {regn, d9, 16'($urandom)};
    wr(1'b0, dv);
    check(data_q == dv, "R2 data store", data_q, dv);
    k = 3;
    for (int i = 2; i >= 0; i--) if (!mask[i]) k = i;
    kk = (k > 2) ? 2 : k;
    ecyc = exp_cycles(k);
    ack_en = mask;
    s0 = nstart; p0 = nstop;
    wr(1'b1, 32'h0000_0500 | {24'd0, ad});
    check(ctrl_q[9:8] == 2'b01, "R9 start sets valid clears abort", {30'd0, ctrl_q[9:8]}, 32'h1);
    cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      reg_wr = 1'b0;
      if (!ctrl_q[8] || cnt > ecyc + 50) break;
      if (cnt == 5) begin reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = ~dv; end
      if (cnt == 9) begin reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0000_0500 | {24'd0, ~ad}; end
      if (collide && cnt == ecyc - 1) begin reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = dv ^ 32'h5a5a_0000; end
    end
    reg_wr = 1'b0;
    if (k == 3) check(cnt == ecyc, "R6 completion cycle", cnt, ecyc);
    else        check(cnt == ecyc, "R7 nack completion cycle", cnt, ecyc);
    check(ctrl_q[9] == (k < 3), "R7 abort flag", {31'd0, ctrl_q[9]}, {31'd0, k < 3});
    check(data_q == dv, "R8 data write ignored while busy", data_q, dv);
    check(ctrl_q[7:0] == ad, "R8 control write ignored while busy", ctrl_q[7:0], ad);
    for (int i = 0; i <= kk; i++)
      check(rx[i] == exp_byte(dv, ad, i), "R4 byte on bus", rx[i], exp_byte(dv, ad, i));
    check(mbits == 9 * (kk + 1) + 1, "R4 clock count incl stop", mbits, 9 * (kk + 1) + 1);
    check(nstart == s0 + 1 && nstop == p0 + 1, "R4 one start one stop", nstop - p0, 1);
    if (collide) begin
      wr(1'b0, dv ^ 32'h0f0f_0000);
      check(data_q == (dv ^ 32'h0f0f_0000), "R8 write accepted after completion",
            data_q, dv ^ 32'h0f0f_0000);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check(ctrl_q == 32'd0, "R1 reset ctrl", ctrl_q, 0);
    check(data_q == 32'd0, "R1 reset data", data_q, 0);
    check(!scl_oe && !sda_oe, "R1 reset lines", {30'd0, scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    txn(7'h15, 9'h002, 8'h34, 3'b111, 1'b0);

    // R3: valid without write-select does not start
    wr(1'b1, 32'h0000_0134);
    check(ctrl_q[8] == 1'b0, "R3 no start without bit10", {31'd0, ctrl_q[8]}, 0);
    begin
      int s0;
      s0 = nstart;
      repeat (40) @(negedge clk);
      check(nstart == s0 && !scl_oe && !sda_oe, "R3 bus stays idle", nstart - s0, 0);
    end

    txn(7'h2a, 9'h155, 8'h34, 3'b110, 1'b0);   // R7 nack on address
    txn(7'h01, 9'h1ff, 8'h34, 3'b111, 1'b0);   // R9 abort cleared by new start
    check(ctrl_q[9] == 1'b0, "R9 abort cleared", {31'd0, ctrl_q[9]}, 0);
    txn(7'h7f, 9'h000, 8'h34, 3'b101, 1'b0);   // R7 nack on high byte
    txn(7'h40, 9'h0aa, 8'h34, 3'b011, 1'b0);   // R7 nack on low byte
    txn(7'h33, 9'h123, 8'h34, 3'b111, 1'b1);   // R8 collision at completion edge

    for (int n = 0; n < 16; n++) begin
      logic [2:0] m;
      m = ($urandom % 4 == 0) ? 3'($urandom) : 3'b111;
      txn(7'($urandom), 9'($urandom), 8'($urandom) & 8'hfe, m, ($urandom % 3) == 0);
    end

    check(bad_hi == 0, "R5 scl high pulse width", bad_hi, 0);
    check(nstart == nstop, "R5 start stop pairing", nstop, nstart);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule